// File: doc/BRIEF.md
# Display Frame Buffer Address Generator

This block turns pixel coordinates and a display mode into graphics-memory requests. Each request is a 20-bit DWORD offset inside a graphics aperture, plus four byte enables. The block also gives the system byte address of the request, found from the aperture base. Each mode fixes the visible width, the height, the bytes per pixel and the line pitch. The frame buffer is addressed in XY form: the line number is shifted by the pitch and the byte X position is added to it.

The block has two paths that work independently. The single-access path takes X, Y and the mode and answers one cycle later. It returns either the offset and the byte enables that select one pixel, or an error. The raster sequencer starts on a pulse and walks the frame one line at a time. On each line it first fetches every visible DWORD, then issues one request for that line's compressed display data. When a line is shorter than the pitch, the compressed data sits in the unused tail of the line's slot. When a line fills the whole pitch, the compressed data sits in a separate linear region with a programmable start and stride. Any offset at or beyond the programmed aperture size is suppressed and flagged.

Top module: `fbaddr_gen`

## Requirements
- R1: The mode code is `{res[1:0], deep}`. The res values 0, 1, 2 and 3 select 640x480, 800x600, 1024x768 and 1280x1024. deep=0 selects 1 byte per pixel and deep=1 selects 2 bytes per pixel. Code 3'b111 (1280x1024 at 2 bytes per pixel) is rejected: an access with it raises `acc_err`, and a start with it raises `ras_err` in the same cycle and issues no request.
- R2: An accepted access answers on the cycle after `acc_valid`. The offset is `acc_y*P + (acc_x*bytes_per_pixel)/4` in DWORDs. P is 512 DWORDs when the visible line has more than 1024 bytes and 256 DWORDs otherwise.
- R3: At 1 byte per pixel, `acc_be` is `1 << acc_x[1:0]`. At 2 bytes per pixel it is 4'b0011 when `acc_x[0]` is 0 and 4'b1100 when it is 1.
- R4: When X is at or beyond the visible width, or Y is at or beyond the height, `acc_err` pulses and `acc_rsp_valid` stays low.
- R5: The aperture limit is `apt_size * 131072` DWORDs, with `apt_size` counted in 512 KB units. A computed offset at or above this limit is suppressed. For an access this raises `acc_err`. For the sequencer it raises `ras_err` for one cycle, and the sequence moves on without waiting for `rq_ready`.
- R6: `acc_addr` and `rq_addr` are `apt_base*524288 + 4*offset`.
- R7: After a start, the sequencer issues lines 0 to L-1, where L = min(height, MAX_LINES). Each line is DWORDs 0 to N-1 at `line*P + i` with `rq_comp`=0, followed by one request with `rq_comp`=1. N is the number of visible DWORDs in a line.
- R8: When N < P, the compressed request of a line is at `line*P + N`.
- R9: When N = P (the 1024x768 modes), the compressed request of a line is at `comp_base + line*comp_stride`. `comp_base` and `comp_stride` are captured at start.
- R10: While `rq_valid` is high and `rq_ready` is low, the request holds with the same offset and kind.
- R11: `ras_done` pulses for one cycle, in the cycle after the final request is accepted or suppressed. A start that arrives while a run is in progress is ignored.
- R12: Sequencer requests always carry `rq_be` = 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Display mode code {res, deep} |
| apt_base | input | BASE_W | Aperture base in 512 KB units |
| apt_size | input | 4 | Aperture size in 512 KB units |
| comp_base | input | 20 | DWORD start of the linear compressed region |
| comp_stride | input | STRIDE_W | DWORDs between compressed lines in the linear region |
| acc_valid | input | 1 | Single-access request strobe |
| acc_x | input | 11 | Pixel X |
| acc_y | input | 11 | Pixel Y |
| acc_rsp_valid | output | 1 | Access response valid |
| acc_ofs | output | 20 | Access DWORD offset |
| acc_be | output | 4 | Access byte enables |
| acc_addr | output | BASE_W+19 | Access system byte address |
| acc_err | output | 1 | Access rejected |
| ras_start | input | 1 | Start pulse for a raster run |
| rq_ready | input | 1 | Memory side accepts the current request |
| rq_valid | output | 1 | Raster request valid |
| rq_ofs | output | 20 | Raster DWORD offset |
| rq_be | output | 4 | Raster byte enables |
| rq_comp | output | 1 | Request is compressed-line data |
| rq_addr | output | BASE_W+19 | Raster system byte address |
| ras_err | output | 1 | Raster request suppressed or start rejected |
| ras_done | output | 1 | Raster run finished |

## Verification
The aperture and hold properties assume that `apt_size` and `apt_base` do not change while a raster run is active or an access response is pending. The bench changes these inputs only together with a new access, or between runs. The hold property also assumes that `rq_ready` is the only input the request depends on during a run. The bench therefore changes `mode` in the middle of a run only in the cycle where it sends an ignored start. The coordinate sweeps cover every X of every valid mode on the first and last lines. The sequencer runs use a short line cap, so whole frames complete in each mode with and without back-pressure.

// File: rtl/fbaddr_pkg.sv
package fbaddr_pkg;
    localparam int OFS_W        = 20;  // DWORD offset width
    localparam int CRD_W        = 11;  // coordinate width
    localparam int APT_DW_LG2   = 17;  // DWORDs per 512 KB unit
    localparam int APT_BYTE_LG2 = 19;  // bytes per 512 KB unit

    typedef enum logic [1:0] {
        RES_640  = 2'd0,
        RES_800  = 2'd1,
        RES_1024 = 2'd2,
        RES_1280 = 2'd3
    } res_e;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_FETCH = 2'd1,
        RS_COMP  = 2'd2
    } ras_st_e;

    typedef struct packed {
        logic             ok;
        logic             deep;
        logic             linear;
        logic [CRD_W-1:0] width;
        logic [CRD_W-1:0] height;
        logic [3:0]       pitch_lg2;  // DWORDs per line, log2
        logic [CRD_W-1:0] vis_dw;     // visible DWORDs per line
    } geom_t;

    function automatic geom_t mode_geom(input logic [2:0] m);
        geom_t g;
        g      = '0;
        g.deep = m[0];
        case (res_e'(m[2:1]))
            RES_640:  begin g.width = CRD_W'(640);  g.height = CRD_W'(480);  end
            RES_800:  begin g.width = CRD_W'(800);  g.height = CRD_W'(600);  end
            RES_1024: begin g.width = CRD_W'(1024); g.height = CRD_W'(768);  end
            default:  begin g.width = CRD_W'(1280); g.height = CRD_W'(1024); end
        endcase
        g.ok        = !((m[2:1] == RES_1280) && m[0]);
        g.pitch_lg2 = (m[0] || (m[2:1] == RES_1280)) ? 4'd9 : 4'd8;
        g.vis_dw    = m[0] ? (g.width >> 1) : (g.width >> 2);
        g.linear    = (m[2:1] == RES_1024);
        return g;
    endfunction

    function automatic logic in_apt(input logic [OFS_W-1:0] o, input logic [3:0] sz);
        logic [OFS_W+3:0] lim;
        lim = (OFS_W+4)'(sz) << APT_DW_LG2;
        return ({4'b0, o} < lim);
    endfunction
endpackage

// File: rtl/fbaddr_mode_dec.sv
module fbaddr_mode_dec
    import fbaddr_pkg::*;
(
    input  logic [2:0] mode,
    output geom_t      geom
);
    always_comb geom = mode_geom(mode);
endmodule

// File: rtl/fbaddr_pix.sv
module fbaddr_pix
    import fbaddr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [CRD_W-1:0] x,
    input  logic [CRD_W-1:0] y,
    input  geom_t            g,
    input  logic [3:0]       apt_size,
    output logic             rsp_valid,
    output logic             err,
    output logic [OFS_W-1:0] ofs,
    output logic [3:0]       be
);
    logic [OFS_W-1:0] row_ofs, col_ofs, nxt_ofs;
    logic [3:0]       nxt_be;
    logic             bad;

    always_comb begin
        row_ofs = OFS_W'(y) << g.pitch_lg2;
        if (g.deep) begin
            col_ofs = OFS_W'(x >> 1);
            nxt_be  = x[0] ? 4'b1100 : 4'b0011;
        end else begin
            col_ofs = OFS_W'(x >> 2);
            nxt_be  = 4'b0001 << x[1:0];
        end
        nxt_ofs = row_ofs + col_ofs;
        bad     = !g.ok || (x >= g.width) || (y >= g.height) || !in_apt(nxt_ofs, apt_size);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            err       <= 1'b0;
            ofs       <= '0;
            be        <= '0;
        end else begin
            rsp_valid <= acc_valid && !bad;
            err       <= acc_valid && bad;
            if (acc_valid && !bad) begin
                ofs <= nxt_ofs;
                be  <= nxt_be;
            end else begin
                be  <= '0;
            end
        end
    end
endmodule

// File: rtl/fbaddr_raster.sv
module fbaddr_raster
    import fbaddr_pkg::*;
#(
    parameter int MAX_LINES = 2048,
    parameter int STRIDE_W  = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  geom_t               g_live,
    input  logic [3:0]          apt_size,
    input  logic [OFS_W-1:0]    comp_base,
    input  logic [STRIDE_W-1:0] comp_stride,
    input  logic                ready,
    output logic                valid,
    output logic [OFS_W-1:0]    ofs,
    output logic                comp,
    output logic                err,
    output logic                done
);
    localparam int CAP = (MAX_LINES < 1) ? 1 : ((MAX_LINES > 1024) ? 1024 : MAX_LINES);
    localparam logic [CRD_W-1:0] CAP_L = CRD_W'(CAP);

    ras_st_e             st;
    geom_t               g;
    logic [CRD_W-1:0]    line, col, n_lines;
    logic [OFS_W-1:0]    line_base, lin_comp, cur;
    logic [STRIDE_W-1:0] stride;
    logic                active, oob, adv, last_col, last_line;

    always_comb begin
        active = (st != RS_IDLE);
        if (st == RS_COMP)
            cur = g.linear ? lin_comp : (line_base + OFS_W'(g.vis_dw));
        else
            cur = line_base + OFS_W'(col);
        oob       = !in_apt(cur, apt_size);
        adv       = active && (oob || ready);
        last_col  = (col == g.vis_dw - 1'b1);
        last_line = (line == n_lines - 1'b1);
    end

    assign valid = active && !oob;
    assign ofs   = cur;
    assign comp  = (st == RS_COMP);
    assign err   = (active && oob) || ((st == RS_IDLE) && start && !g_live.ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RS_IDLE;
            g         <= '0;
            line      <= '0;
            col       <= '0;
            n_lines   <= '0;
            line_base <= '0;
            lin_comp  <= '0;
            stride    <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                RS_IDLE: if (start && g_live.ok) begin
                    g         <= g_live;
                    line      <= '0;
                    col       <= '0;
                    line_base <= '0;
                    lin_comp  <= comp_base;
                    stride    <= comp_stride;
                    n_lines   <= (g_live.height < CAP_L) ? g_live.height : CAP_L;
                    st        <= RS_FETCH;
                end
                RS_FETCH: if (adv) begin
                    if (last_col) begin
                        col <= '0;
                        st  <= RS_COMP;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                RS_COMP: if (adv) begin
                    if (last_line) begin
                        st   <= RS_IDLE;
                        done <= 1'b1;
                    end else begin
                        line      <= line + 1'b1;
                        line_base <= line_base + (OFS_W'(1) << g.pitch_lg2);
                        lin_comp  <= lin_comp + OFS_W'(stride);
                        st        <= RS_FETCH;
                    end
                end
                default: st <= RS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fbaddr_gen.sv
module fbaddr_gen
    import fbaddr_pkg::*;
#(
    parameter int BASE_W    = 7,
    parameter int STRIDE_W  = 12,
    parameter int MAX_LINES = 2048
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [2:0]                     mode,
    input  logic [BASE_W-1:0]              apt_base,
    input  logic [3:0]                     apt_size,
    input  logic [OFS_W-1:0]               comp_base,
    input  logic [STRIDE_W-1:0]            comp_stride,
    input  logic                           acc_valid,
    input  logic [CRD_W-1:0]               acc_x,
    input  logic [CRD_W-1:0]               acc_y,
    output logic                           acc_rsp_valid,
    output logic [OFS_W-1:0]               acc_ofs,
    output logic [3:0]                     acc_be,
    output logic [BASE_W+APT_BYTE_LG2-1:0] acc_addr,
    output logic                           acc_err,
    input  logic                           ras_start,
    input  logic                           rq_ready,
    output logic                           rq_valid,
    output logic [OFS_W-1:0]               rq_ofs,
    output logic [3:0]                     rq_be,
    output logic                           rq_comp,
    output logic [BASE_W+APT_BYTE_LG2-1:0] rq_addr,
    output logic                           ras_err,
    output logic                           ras_done
);
    localparam int ADDR_W = BASE_W + APT_BYTE_LG2;

    geom_t             geom_now;
    logic [ADDR_W-1:0] base_bytes;

    fbaddr_mode_dec u_dec (
        .mode (mode),
        .geom (geom_now)
    );

    fbaddr_pix u_pix (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .x         (acc_x),
        .y         (acc_y),
        .g         (geom_now),
        .apt_size  (apt_size),
        .rsp_valid (acc_rsp_valid),
        .err       (acc_err),
        .ofs       (acc_ofs),
        .be        (acc_be)
    );

    fbaddr_raster #(
        .MAX_LINES (MAX_LINES),
        .STRIDE_W  (STRIDE_W)
    ) u_ras (
        .clk         (clk),
        .rst         (rst),
        .start       (ras_start),
        .g_live      (geom_now),
        .apt_size    (apt_size),
        .comp_base   (comp_base),
        .comp_stride (comp_stride),
        .ready       (rq_ready),
        .valid       (rq_valid),
        .ofs         (rq_ofs),
        .comp        (rq_comp),
        .err         (ras_err),
        .done        (ras_done)
    );

    assign base_bytes = {apt_base, {APT_BYTE_LG2{1'b0}}};
    assign acc_addr   = base_bytes + ADDR_W'({acc_ofs, 2'b00});
    assign rq_addr    = base_bytes + ADDR_W'({rq_ofs, 2'b00});
    assign rq_be      = 4'hF;
endmodule

// File: rtl/fbaddr_chk.sv
module fbaddr_chk
    import fbaddr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic             acc_rsp_valid,
    input logic             acc_err,
    input logic [3:0]       acc_be,
    input logic [OFS_W-1:0] acc_ofs,
    input logic [3:0]       apt_size,
    input logic             rq_valid,
    input logic             rq_ready,
    input logic [OFS_W-1:0] rq_ofs,
    input logic             rq_comp,
    input logic             ras_done
);
    logic [23:0] lim_dw;
    assign lim_dw = 24'(apt_size) * 24'd131072;

    p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (rst)
        acc_rsp_valid |-> $past(acc_valid));

    p_be_shape_r3: assert property (@(posedge clk) disable iff (rst)
        acc_rsp_valid |-> ($countones(acc_be) == 1 || acc_be == 4'b0011 || acc_be == 4'b1100));

    p_rsp_err_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(acc_rsp_valid && acc_err));

    p_acc_in_apt_r5: assert property (@(posedge clk) disable iff (rst)
        acc_rsp_valid |-> ({4'b0, acc_ofs} < lim_dw));

    p_rq_in_apt_r5: assert property (@(posedge clk) disable iff (rst)
        rq_valid |-> ({4'b0, rq_ofs} < lim_dw));

    p_hold_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (rq_valid && !rq_ready) |=> (rq_valid && $stable(rq_ofs) && $stable(rq_comp)));

    p_done_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        ras_done |-> !rq_valid);

    p_done_after_comp_r11: assert property (@(posedge clk) disable iff (rst)
        ras_done |-> $past(rq_comp));
endmodule

bind fbaddr_gen fbaddr_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .acc_valid     (acc_valid),
    .acc_rsp_valid (acc_rsp_valid),
    .acc_err       (acc_err),
    .acc_be        (acc_be),
    .acc_ofs       (acc_ofs),
    .apt_size      (apt_size),
    .rq_valid      (rq_valid),
    .rq_ready      (rq_ready),
    .rq_ofs        (rq_ofs),
    .rq_comp       (rq_comp),
    .ras_done      (ras_done)
);

// File: tb/fbaddr_gen_tb.sv
`timescale 1ns/1ps
module fbaddr_gen_tb;
    localparam int BASE_W = 7;
    localparam int STRIDE_W = 12;
    localparam int LCAP = 3;
    localparam int BASE_VAL = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] mode = '0;
    logic [BASE_W-1:0] apt_base = BASE_W'(BASE_VAL);
    logic [3:0] apt_size = 4'd8;
    logic [19:0] comp_base = '0;
    logic [STRIDE_W-1:0] comp_stride = '0;
    logic acc_valid = 1'b0;
    logic [10:0] acc_x = '0, acc_y = '0;
    logic acc_rsp_valid, acc_err, rq_valid, rq_comp, ras_err, ras_done;
    logic [19:0] acc_ofs, rq_ofs;
    logic [3:0] acc_be, rq_be;
    logic [BASE_W+18:0] acc_addr, rq_addr;
    logic ras_start = 1'b0;
    logic rq_ready = 1'b0;

    int n_tests = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fbaddr_gen #(.BASE_W(BASE_W), .STRIDE_W(STRIDE_W), .MAX_LINES(LCAP)) u_dut (
        .clk(clk), .rst(rst), .mode(mode), .apt_base(apt_base), .apt_size(apt_size),
        .comp_base(comp_base), .comp_stride(comp_stride),
        .acc_valid(acc_valid), .acc_x(acc_x), .acc_y(acc_y),
        .acc_rsp_valid(acc_rsp_valid), .acc_ofs(acc_ofs), .acc_be(acc_be),
        .acc_addr(acc_addr), .acc_err(acc_err),
        .ras_start(ras_start), .rq_ready(rq_ready), .rq_valid(rq_valid),
        .rq_ofs(rq_ofs), .rq_be(rq_be), .rq_comp(rq_comp), .rq_addr(rq_addr),
        .ras_err(ras_err), .ras_done(ras_done)
    );

    task automatic chk(input bit c, input string r, input longint act, input longint exp);
        n_tests++;
        if (!c) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic geo(input int m, output int w, output int h, output int bpb,
                       output int p, output bit lin, output bit ok);
        int r;
        r   = m >> 1;
        bpb = (m % 2 == 1) ? 2 : 1;
        case (r)
            0: begin w = 640;  h = 480;  end
            1: begin w = 800;  h = 600;  end
            2: begin w = 1024; h = 768;  end
            default: begin w = 1280; h = 1024; end
        endcase
        ok  = !(r == 3 && bpb == 2);
        p   = (w * bpb > 1024) ? 512 : 256;
        lin = (w * bpb == p * 4);
    endtask

    task automatic do_acc(input int m, input int x, input int y, input int size);
        int w, h, bpb, p, ebe;
        bit lin, ok, ebad;
        longint eo;
        geo(m, w, h, bpb, p, lin, ok);
        @(negedge clk);
        mode = 3'(m); apt_size = 4'(size); acc_valid = 1'b1;
        acc_x = 11'(x); acc_y = 11'(y);
        @(negedge clk);
        acc_valid = 1'b0;
        eo   = longint'(y) * p + (x * bpb) / 4;
        ebad = !ok || x >= w || y >= h || eo >= longint'(size) * 131072;
        ebe  = (bpb == 1) ? (1 << (x % 4)) : ((x % 2 == 1) ? 12 : 3);
        if (ebad) begin
            // R1 R4 R5: rejected accesses raise the error and give no response
            chk(acc_err && !acc_rsp_valid, "R4/R1/R5 reject", {acc_err, acc_rsp_valid}, 2);
        end else begin
            chk(acc_rsp_valid && !acc_err, "R2 valid", {acc_rsp_valid, acc_err}, 2);
            chk(acc_ofs == 20'(eo), "R2 offset", acc_ofs, eo);
            chk(acc_be == 4'(ebe), "R3 byte enables", acc_be, ebe);
            chk(longint'(acc_addr) == longint'(BASE_VAL) * 524288 + eo * 4, "R6 address",
                acc_addr, longint'(BASE_VAL) * 524288 + eo * 4);
        end
    endtask

    function automatic longint item_ofs(input int k, input int nd, input int p, input bit lin,
                                        input int cb, input int st, output bit isc);
        int ln, j;
        ln  = k / (nd + 1);
        j   = k % (nd + 1);
        isc = (j == nd);
        if (!isc) return longint'(ln) * p + j;
        if (lin) return longint'(cb) + longint'(ln) * st;
        return longint'(ln) * p + nd;
    endfunction

    task automatic run_ras(input int m, input int size, input int cb, input int st,
                           input bit stall, input bit poke);
        int w, h, bpb, p, nd, nl, total, k, errs_exp, errs_seen, last_evt;
        bit lin, ok, isc, seen_done, prev_stall;
        longint eo, prev_ofs, lim;
        geo(m, w, h, bpb, p, lin, ok);
        nd    = w * bpb / 4;
        nl    = (h < LCAP) ? h : LCAP;
        total = nl * (nd + 1);
        lim   = longint'(size) * 131072;
        errs_exp = 0;
        for (int i = 0; i < total; i++) begin
            eo = item_ofs(i, nd, p, lin, cb, st, isc);
            if (eo >= lim) errs_exp++;
        end
        k = 0; errs_seen = 0; last_evt = -10; seen_done = 0; prev_stall = 0; prev_ofs = 0;
        @(negedge clk);
        mode = 3'(m); apt_size = 4'(size); comp_base = 20'(cb);
        comp_stride = STRIDE_W'(st); ras_start = 1'b1; rq_ready = 1'b0;
        for (int cyc = 0; cyc < 5000 && !seen_done; cyc++) begin
            @(negedge clk);
            ras_start = poke && (cyc == 5);
            mode      = (poke && cyc == 5) ? 3'd6 : 3'(m);
            rq_ready  = stall ? (cyc % 3 != 1) : 1'b1;
            #1;
            if (prev_stall) begin
                chk(rq_valid && rq_ofs == 20'(prev_ofs), "R10 hold", rq_ofs, prev_ofs);
            end
            prev_stall = rq_valid && !rq_ready;
            prev_ofs   = rq_ofs;
            if (ras_done) begin
                seen_done = 1;
                chk(last_evt == cyc - 1, "R11 done timing", last_evt, cyc - 1);
            end
            if (ras_err) begin
                errs_seen++;
                last_evt = cyc;
            end
            if (rq_valid && rq_ready) begin
                eo = item_ofs(k, nd, p, lin, cb, st, isc);
                while (k < total && eo >= lim) begin
                    k++;
                    eo = item_ofs(k, nd, p, lin, cb, st, isc);
                end
                // R7 order; R8 gap placement; R9 linear placement
                chk(rq_ofs == 20'(eo), lin ? "R9/R7 offset" : "R8/R7 offset", rq_ofs, eo);
                chk(rq_comp == isc, "R7 kind", rq_comp, isc);
                chk(rq_be == 4'hF, "R12 byte enables", rq_be, 15);
                chk(longint'(rq_addr) == longint'(BASE_VAL) * 524288 + eo * 4, "R6 raster address",
                    rq_addr, longint'(BASE_VAL) * 524288 + eo * 4);
                k++;
                last_evt = cyc;
            end
        end
        while (k < total) begin
            eo = item_ofs(k, nd, p, lin, cb, st, isc);
            if (eo < lim) break;
            k++;
        end
        rq_ready = 1'b0;
        chk(k == total, "R7 count", k, total);
        chk(errs_seen == errs_exp, "R5 suppressed", errs_seen, errs_exp);
        chk(seen_done, "R11 done seen", seen_done, 1);
        @(negedge clk);
        chk(!rq_valid && !ras_done, "R11 single pulse", {rq_valid, ras_done}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int w, h, bpb, p;
        bit lin, ok;
        repeat (4) @(negedge clk);
        chk(!acc_rsp_valid && !acc_err && !rq_valid && !ras_done && !ras_err,
            "R11 reset state", {acc_rsp_valid, acc_err, rq_valid, ras_done, ras_err}, 0);
        rst = 1'b0;

        // R2 R3 R6: every X on first and last lines of every valid mode
        for (int m = 0; m < 7; m++) begin
            geo(m, w, h, bpb, p, lin, ok);
            for (int x = 0; x < w; x++) begin
                do_acc(m, x, 0, 8);
                do_acc(m, x, h - 1, 8);
            end
            do_acc(m, w / 2 + 1, h / 2, 8);
            do_acc(m, w, 0, 8);       // R4 X at width
            do_acc(m, 0, h, 8);       // R4 Y at height
        end
        // R1: rejected mode combination
        do_acc(7, 0, 0, 8);
        do_acc(7, 100, 10, 8);
        // R5: aperture boundary with one 512 KB unit
        do_acc(5, 1023, 255, 1);
        do_acc(5, 0, 256, 1);
        do_acc(5, 0, 767, 1);
        do_acc(4, 1020, 511, 1);
        do_acc(4, 0, 512, 1);
        do_acc(0, 0, 0, 0);

        // R7 R8 R9 R10 R11 R12: full (capped) frames in every valid mode
        for (int m = 0; m < 7; m++) begin
            run_ras(m, 8, 20'h80000 + m, 300 + m, m % 2 == 1, m == 2);
        end
        run_ras(4, 8, 0, 256, 1'b1, 1'b0);
        // R5: linear compressed lines crossing the aperture limit
        run_ras(4, 1, 131062, 10, 1'b0, 1'b0);
        run_ras(5, 1, 131062, 10, 1'b1, 1'b0);

        // R1: start with rejected mode
        @(negedge clk);
        mode = 3'd7; ras_start = 1'b1;
        #1;
        chk(ras_err, "R1 start reject", ras_err, 1);
        @(negedge clk);
        ras_start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!rq_valid && !ras_done, "R1 no requests", {rq_valid, ras_done}, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule